// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs PHY management transactions on a two-wire MDC/MDIO link. Software writes one 32-bit command word that already holds the complete frame: start code, operation, PHY address, register address, turnaround code and data. If management is enabled and the engine is idle, that write starts a transaction. The engine first sends a preamble of 32 ones. It then shifts the 32 command bits out most significant bit first. MDC is a divided copy of the system clock, and the divide ratio is chosen by a 2-bit code.

On a read the engine stops driving the line for the turnaround and data phases. It samples the PHY's 16 data bits on rising MDC edges and writes them into the low half of the stored word, where software reads them back. An idle flag shows whether a frame is in flight. A synchronised copy of the MDIO input is always visible. A single-cycle done pulse marks each completed frame and can feed an interrupt. The MDIO pad is represented as separate input, output and output-enable signals.

Top module: `mdio_master`

## Requirements
- R1: After reset, idle is 1, done is 0, mdc is 0, mdio_oe is 0 and the stored command word reads 0.
- R2: A write with mgmt_en high while idle stores cmd_wdata and starts a frame. idle reads 0 from the next cycle. The done pulse appears exactly 64 MDC periods after the write edge.
- R3: The MDC period is 8, 16, 32 or 64 system clocks for div_sel codes 0, 1, 2 and 3, with the code sampled at frame start. MDC is low for the first half of each bit time and high for the second half, giving exactly 64 rising edges per frame.
- R4: The bit stream is 32 ones followed by command bits 31 down to 0. Each bit changes only as MDC falls, so it is stable at every rising edge.
- R5: When command bits 29:28 equal 2'b10 (read), mdio_oe is low for the last 18 bit times, which are the turnaround and the 16 data bits. For any other operation mdio_oe stays high for all 64 bit times.
- R6: On a read, the 16 mdio_i values sampled on the rising MDC edges of the last 16 bit times, first sample in bit 15, replace word bits 15:0. Bits 31:16 are unchanged. A write frame leaves the word unchanged.
- R7: done is high for exactly one system clock at frame completion, and idle returns to 1 in that same cycle.
- R8: A write that arrives while a frame is in progress is ignored. It changes neither the bit stream nor the stored word.
- R9: While mgmt_en is low, writes neither start a frame nor update the word, and mdc and mdio_oe stay low.
- R10: Clearing mgmt_en during a frame aborts it. idle returns to 1 on the next cycle, mdc and mdio_oe go low, and no done pulse is produced.
- R11: mdio_level follows mdio_i through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management enable |
| div_sel | input | 2 | MDC divide code (8 << code) |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write data |
| cmd_rdata | output | 32 | Stored command word, with read data merged in |
| idle | output | 1 | High when no frame is in progress |
| mdio_level | output | 1 | Synchronised level of the MDIO input |
| done | output | 1 | One-cycle frame completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
Each frame is timed from the write edge to the done pulse at all four divide codes. A counter that wraps at the wrong value or misdecodes the code gives the wrong cycle count or the wrong high time. The bench records mdio_o and mdio_oe at every rising MDC edge. That catches a stream sent LSB first, a short preamble, or a bus released one bit early or late. A PHY model returns distinct patterns so that bit-order or off-by-one errors in the capture show up in the read-back word. Writes arriving mid-frame, writes made with management disabled, and an abort part way through a frame expose a design that restarts, overwrites the word, or still raises done.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_BITS  = 32,
  parameter int FRAME_W   = 32,
  parameter int DATA_W    = 16,
  parameter int RELEASE_AT = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mgmt_en,
  input  logic [1:0]         div_sel,
  input  logic               cmd_we,
  input  logic [FRAME_W-1:0] cmd_wdata,
  output logic [FRAME_W-1:0] cmd_rdata,
  output logic               idle,
  output logic               mdio_level,
  output logic               done,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  localparam int TOTAL  = PRE_BITS + FRAME_W;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] CAP_FROM = IDX_W'(TOTAL - DATA_W);
  localparam logic [IDX_W-1:0] REL_FROM = IDX_W'(PRE_BITS + RELEASE_AT);

  logic               busy;
  logic [FRAME_W-1:0] word;
  logic [5:0]         cnt;
  logic [IDX_W-1:0]   bitidx;
  logic [1:0]         div_q;
  logic [DATA_W-1:0]  cap;
  logic [1:0]         sync;
  logic [5:0]         last_cnt, half_m1;
  logic               is_read, bit_end, rise;

  assign last_cnt = 6'((7'd8 << div_q) - 7'd1);
  assign half_m1  = 6'((7'd4 << div_q) - 7'd1);
  assign is_read  = word[FRAME_W-3 -: 2] == 2'b10;
  assign bit_end  = busy && cnt == last_cnt;
  assign rise     = busy && cnt == half_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
      cnt    <= '0;
      bitidx <= '0;
      div_q  <= '0;
      cap    <= '0;
      sync   <= '0;
    end else begin
      done <= 1'b0;
      sync <= {sync[0], mdio_i};
      if (!mgmt_en) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (cmd_we) begin
          word   <= cmd_wdata;
          busy   <= 1'b1;
          cnt    <= '0;
          bitidx <= '0;
          div_q  <= div_sel;
        end
      end else begin
        if (rise && bitidx >= CAP_FROM)
          cap <= {cap[DATA_W-2:0], sync[1]};
        if (bit_end) begin
          cnt <= '0;
          if (bitidx == LAST_BIT) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_read) word[DATA_W-1:0] <= cap;
          end else begin
            bitidx <= bitidx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign cmd_rdata  = word;
  assign idle       = ~busy;
  assign mdio_level = sync[1];
  assign mdc        = busy && cnt > half_m1;
  assign mdio_o     = (bitidx < IDX_W'(PRE_BITS)) ? 1'b1 : word[~bitidx[BIT_W-1:0]];
  assign mdio_oe    = busy && !(is_read && bitidx >= REL_FROM);
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mgmt_en,
  input logic        cmd_we,
  input logic        idle,
  input logic        done,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [31:0] cmd_rdata
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_we && mgmt_en) |=> !idle);
  assert_mdc_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> !idle);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(cmd_rdata) || done));
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdc && !mdio_oe));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |=> (idle && !done));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .cmd_we(cmd_we),
  .idle(idle), .done(done), .mdc(mdc), .mdio_oe(mdio_oe), .cmd_rdata(cmd_rdata)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_en = 1'b0;
  logic [1:0]  div_sel = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdio_level, done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .div_sel(div_sel),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdio_level(mdio_level), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // div[49:48], command word[47:16], PHY response[15:0]
  localparam logic [49:0] VEC [4] = '{
    {2'd0, 32'h5192ABCD, 16'h0000},
    {2'd1, 32'h62AA0000, 16'hC3A5},
    {2'd3, 32'h5F860F0F, 16'h0000},
    {2'd2, 32'h607EFFFF, 16'h1E01}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] div, input logic [31:0] w,
                           input logic [15:0] resp, input bit poke,
                           input logic [31:0] poke_w);
    int cyc, rcnt, hi, bad_bits, bad_oe, period;
    bit prev, is_rd, got_done;
    logic [31:0] exp_word;
    period = 8 << div;
    is_rd = (w[29:28] == 2'b10);
    exp_word = is_rd ? {w[31:16], resp} : w;
    @(negedge clk);
    div_sel = div; cmd_wdata = w; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    check(idle == 1'b0, "R2 idle low in frame", 64'(idle), 64'd0);
    cyc = 0; rcnt = 0; hi = 0; bad_bits = 0; bad_oe = 0; prev = mdc; got_done = 0;
    while (cyc < 20000) begin
      if (poke && cyc == 100) begin cmd_wdata = poke_w; cmd_we = 1'b1; end
      if (poke && cyc == 101) cmd_we = 1'b0;
      @(negedge clk);
      cyc++;
      if (mdc) hi++;
      if (mdc && !prev) begin
        if (rcnt < 64) begin
          if (mdio_oe && mdio_o !== ((rcnt < 32) ? 1'b1 : w[63-rcnt])) bad_bits++;
          if (mdio_oe !== !(is_rd && rcnt >= 46)) bad_oe++;
        end
        rcnt++;
      end
      if (!mdc && prev && rcnt >= 48 && rcnt < 64) mdio_i = resp[63-rcnt];
      prev = mdc;
      if (done) begin got_done = 1; break; end
    end
    mdio_i = 1'b1;
    check(got_done && cyc == 64 * period, "R2 frame length", 64'(cyc), 64'(64 * period));
    check(rcnt == 64, "R3 rising edge count", 64'(rcnt), 64'd64);
    check(hi == 32 * period, "R3 mdc high time", 64'(hi), 64'(32 * period));
    check(bad_bits == 0, "R4 bit stream", 64'(bad_bits), 64'd0);
    check(bad_oe == 0, "R5 output enable", 64'(bad_oe), 64'd0);
    check(idle == 1'b1, "R7 idle with done", 64'(idle), 64'd1);
    check(cmd_rdata == exp_word, poke ? "R8 busy write ignored" : "R6 word after frame",
          64'(cmd_rdata), 64'(exp_word));
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    check(idle == 1'b1 && done == 1'b0, "R1 reset idle/done", {idle, done}, 2'b10);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {mdc, mdio_oe}, 2'b00);
    check(cmd_rdata == 32'd0, "R1 reset word", 64'(cmd_rdata), 64'd0);
    rst_n = 1'b1;

    // R9: disabled writes ignored
    @(negedge clk);
    cmd_wdata = 32'h60000001; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (!idle || mdc || mdio_oe) seen = 1;
    end
    check(!seen, "R9 no frame when disabled", 64'(seen), 64'd0);
    check(cmd_rdata == 32'd0, "R9 word untouched", 64'(cmd_rdata), 64'd0);

    mgmt_en = 1'b1;
    foreach (VEC[i])
      run_frame(VEC[i][49:48], VEC[i][47:16], VEC[i][15:0], 1'b0, 32'd0);

    // R8: write during a frame
    run_frame(2'd0, 32'h51921234, 16'h0000, 1'b1, 32'h62AAFFFF);

    // R10: abort mid-frame
    @(negedge clk);
    div_sel = 2'd0; cmd_wdata = 32'h62AA0000; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (100) @(negedge clk);
    mgmt_en = 1'b0;
    @(negedge clk);
    check(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R10 abort quiet",
          {idle, mdc, mdio_oe}, 3'b100);
    seen = 0;
    repeat (600) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(!seen, "R10 no done after abort", 64'(seen), 64'd0);
    mgmt_en = 1'b1;

    // R11: input level mirror
    mdio_i = 1'b0;
    repeat (3) @(negedge clk);
    check(mdio_level == 1'b0, "R11 level low", 64'(mdio_level), 64'd0);
    mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    check(mdio_level == 1'b1, "R11 level high", 64'(mdio_level), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule